// File: doc/BRIEF.md
# Serial Converter Control Port

This block is the device-side digital port of a 12-bit multichannel sampling converter. The host's serial clock (`sclk_i`) runs it, and an active-low chip select gates it. A falling chip select does not open a transaction. The port waits for the first logic 1 sampled on the data input and treats that bit as the top bit of an 8-bit control byte.

When the byte is complete, the port raises a one-clock strobe and latches the converter's 12 decision bits from a parallel input. It then presents those bits MSB first on the next 12 falling clock edges. The host can keep chip select low and overlap the next control byte with the tail of the current result, so a conversion can be framed every 16 clocks.

The two low control bits request a power mode, which takes effect when the running conversion finishes. An asynchronous active-low shutdown input aborts everything at once.

Top module: `adc_serial_port`

## Requirements
- R1: A start is recognised only on a rising `sclk_i` edge that samples `din_i`=1 while `cs_ni`=0 and the port is waiting. Lowering `cs_ni` alone starts nothing, and a high `din_i` sampled while `cs_ni`=1 starts nothing.
- R2: The control byte is taken MSB first, and the start bit is byte bit 7. Byte bits 6:4 appear on `chan_o` and bits 1:0 on `pwr_req_o`. Both outputs are registered and change only on the rising edge that samples the eighth bit.
- R3: `strb_o` goes high on the falling edge right after the eighth control bit is sampled and stays high for exactly one clock period.
- R4: `result_i` is captured on the edge where the strobe rises. Its bits 11..0 then appear on `dout_o` on the next 12 falling edges, MSB first.
- R5: While `cs_ni`=1, both `dout_oe_o` and `strb_oe_o` are 0 (high impedance). While `cs_ni`=0, both are 1.
- R6: From the eighth control bit until result bit 6 has been driven, `din_i` is ignored. The next rising edge may take a new start bit, so back-to-back 16-clock frames work.
- R7: With `cs_ni` held low, 16 consecutive zero bits on `din_i` return the port to waiting for a start bit from any state.
- R8: The modes are encoded 2'b11 active, 2'b10 and 2'b01 standby, and 2'b00 full power-down. `pwr_state_o` becomes 2'b11 on the strobe edge. It takes the requested mode only on the falling edge that drives result bit 0.
- R9: While `shdn_ni`=0, the port aborts at once: `strb_o`=0, `dout_o`=0 and `pwr_state_o`=2'b00. The aborted conversion never resumes, and a new start bit is needed.
- R10: After reset, and until a conversion delivers data, `dout_o`=0 and `strb_o`=0. At that point `pwr_state_o`=2'b11, `pwr_req_o`=2'b11 and `chan_o`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| sclk_i | input | 1 | Host serial clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cs_ni | input | 1 | Chip select, active low |
| din_i | input | 1 | Serial data from host, sampled on rising edges |
| shdn_ni | input | 1 | Hardware shutdown, active low, asynchronous |
| result_i | input | 12 | Parallel comparator decisions |
| dout_o | output | 1 | Serial result, updated on falling edges |
| dout_oe_o | output | 1 | Drive enable for `dout_o` |
| strb_o | output | 1 | Conversion strobe |
| strb_oe_o | output | 1 | Drive enable for `strb_o` |
| chan_o | output | 3 | Latched channel-select field |
| pwr_req_o | output | 2 | Latched power-mode request field |
| pwr_state_o | output | 2 | Power mode in force |

## Verification
The bench uses the default parameters: an 8-bit control byte, a 12-bit result and re-arming after result bit 6. With these values the re-arm point falls 14 clocks after the start bit. That lets a 16-clock frame overlap its control byte with the last four result bits of the previous frame. The 24-clock frames in the same walk leave idle clocks in which the deferred power mode shows on the output.

// File: rtl/adc_port_pkg.sv
package adc_port_pkg;

  typedef enum logic [1:0] {
    PWR_DOWN   = 2'b00,
    PWR_SLOW   = 2'b01,
    PWR_FAST   = 2'b10,
    PWR_ACTIVE = 2'b11
  } pwr_mode_e;

endpackage

// File: rtl/adc_ctrl_rx.sv
module adc_ctrl_rx #(
  parameter int CTRL_W     = 8,
  parameter int CH_W       = 3,
  parameter int PWR_W      = 2,
  parameter int RES_W      = 12,
  parameter int RELOCK_BIT = 6
) (
  input  logic             clk_i,
  input  logic             rst_ni,      // framing reset (includes shutdown)
  input  logic             cfg_rst_ni,  // field reset
  input  logic             cs_ni,
  input  logic             din_i,
  output logic             done_o,
  output logic [CH_W-1:0]  chan_o,
  output logic [PWR_W-1:0] pwr_o
);

  localparam int LOCK_POS = CTRL_W + RES_W - RELOCK_BIT;
  localparam int POS_W    = $clog2(LOCK_POS + 1);
  localparam int SH_W     = CTRL_W - 2;
  localparam logic [POS_W-1:0] POS_IDLE  = '0;
  localparam logic [POS_W-1:0] POS_FIRST = POS_W'(1);
  localparam logic [POS_W-1:0] POS_LAST  = POS_W'(CTRL_W - 1);
  localparam logic [POS_W-1:0] POS_CONV  = POS_W'(CTRL_W);
  localparam logic [POS_W-1:0] POS_LOCK  = POS_W'(LOCK_POS);

  logic [POS_W-1:0] pos_q;
  logic [SH_W-1:0]  sh_q;
  logic             done_q;
  logic             armed;
  logic             capturing;
  logic             fin;

  assign armed     = (pos_q == POS_IDLE) || (pos_q == POS_LOCK);
  assign capturing = !armed && (pos_q < POS_CONV);
  assign fin       = capturing && !cs_ni && (pos_q == POS_LAST);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pos_q  <= POS_IDLE;
      sh_q   <= '0;
      done_q <= 1'b0;
    end else begin
      done_q <= fin;
      if (armed) begin
        if (!cs_ni && din_i) begin
          pos_q <= POS_FIRST;
          sh_q  <= '0;
        end
      end else if (capturing) begin
        if (!cs_ni) begin
          pos_q <= pos_q + 1'b1;
          sh_q  <= {sh_q[SH_W-2:0], din_i};
        end
      end else begin
        // conversion running: din ignored until relock point
        pos_q <= pos_q + 1'b1;
      end
    end
  end

  always_ff @(posedge clk_i or negedge cfg_rst_ni) begin
    if (!cfg_rst_ni) begin
      chan_o <= '0;
      pwr_o  <= '1;
    end else if (fin) begin
      chan_o <= sh_q[SH_W-1 -: CH_W];
      pwr_o  <= {sh_q[PWR_W-2:0], din_i};
    end
  end

  assign done_o = done_q;

  AST_START_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (armed && (cs_ni || !din_i)) |=> (pos_q == $past(pos_q))); // R1

  AST_BUSY_STEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!armed && (pos_q >= POS_CONV)) |=> (pos_q == $past(pos_q) + 1'b1)); // R6

  AST_DONE_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_q |=> !done_q); // R2

endmodule

// File: rtl/adc_conv_shift.sv
module adc_conv_shift #(
  parameter int RES_W = 12
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             load_i,
  input  logic [RES_W-1:0] result_i,
  output logic             strb_o,
  output logic             dout_o,
  output logic             last_o
);

  localparam int CNT_W = $clog2(RES_W + 1);
  localparam logic [CNT_W-1:0] CNT_FULL = CNT_W'(RES_W);
  localparam logic [CNT_W-1:0] CNT_ONE  = CNT_W'(1);

  logic [RES_W-1:0] sr_q;
  logic [CNT_W-1:0] left_q;
  logic             strb_q;
  logic             dout_q;

  always_ff @(negedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sr_q   <= '0;
      left_q <= '0;
      strb_q <= 1'b0;
      dout_q <= 1'b0;
    end else if (load_i) begin
      sr_q   <= result_i;
      left_q <= CNT_FULL;
      strb_q <= 1'b1;
      dout_q <= 1'b0;
    end else begin
      strb_q <= 1'b0;
      if (left_q != '0) begin
        dout_q <= sr_q[RES_W-1];
        sr_q   <= {sr_q[RES_W-2:0], 1'b0};
        left_q <= left_q - 1'b1;
      end else begin
        dout_q <= 1'b0;
      end
    end
  end

  assign strb_o = strb_q;
  assign dout_o = dout_q;
  assign last_o = (left_q == CNT_ONE);

  AST_STRB_SINGLE: assert property (@(negedge clk_i) disable iff (!rst_ni)
    strb_q |=> !strb_q); // R3

  AST_IDLE_LOW: assert property (@(negedge clk_i) disable iff (!rst_ni)
    ((left_q == '0) && !load_i) |=> !dout_q); // R10

  AST_MSB_FIRST: assert property (@(negedge clk_i) disable iff (!rst_ni)
    load_i |=> ##1 (dout_q == $past(result_i[RES_W-1], 2))); // R4

endmodule

// File: rtl/adc_pwr_ctl.sv
module adc_pwr_ctl
  import adc_port_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       start_i,
  input  logic       last_i,
  input  logic       strb_i,
  input  logic [1:0] req_i,
  output logic [1:0] mode_o
);

  pwr_mode_e mode_q;

  always_ff @(negedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      mode_q <= PWR_ACTIVE;
    else if (start_i) mode_q <= PWR_ACTIVE;
    else if (last_i)  mode_q <= pwr_mode_e'(req_i);
  end

  assign mode_o = mode_q;

  AST_PWR_DEFER: assert property (@(negedge clk_i) disable iff (!rst_ni)
    last_i |=> (mode_o == $past(req_i))); // R8

  AST_PWR_WAKE: assert property (@(negedge clk_i) disable iff (!rst_ni)
    strb_i |-> (mode_q == PWR_ACTIVE)); // R8

endmodule

// File: rtl/adc_serial_port.sv
module adc_serial_port
  import adc_port_pkg::*;
#(
  parameter int CTRL_W     = 8,
  parameter int CH_W       = 3,
  parameter int PWR_W      = 2,
  parameter int RES_W      = 12,
  parameter int RELOCK_BIT = 6
) (
  input  logic             sclk_i,
  input  logic             rst_ni,
  input  logic             cs_ni,
  input  logic             din_i,
  input  logic             shdn_ni,
  input  logic [RES_W-1:0] result_i,
  output logic             dout_o,
  output logic             dout_oe_o,
  output logic             strb_o,
  output logic             strb_oe_o,
  output logic [CH_W-1:0]  chan_o,
  output logic [PWR_W-1:0] pwr_req_o,
  output logic [PWR_W-1:0] pwr_state_o
);

  logic rst_eff_n;
  logic byte_done;
  logic last_bit;
  logic strb;
  logic [PWR_W-1:0] mode;

  // shutdown acts as an asynchronous abort of framing and shifting
  assign rst_eff_n = rst_ni & shdn_ni;

  adc_ctrl_rx #(
    .CTRL_W(CTRL_W), .CH_W(CH_W), .PWR_W(PWR_W),
    .RES_W(RES_W), .RELOCK_BIT(RELOCK_BIT)
  ) u_rx (
    .clk_i     (sclk_i),
    .rst_ni    (rst_eff_n),
    .cfg_rst_ni(rst_ni),
    .cs_ni     (cs_ni),
    .din_i     (din_i),
    .done_o    (byte_done),
    .chan_o    (chan_o),
    .pwr_o     (pwr_req_o)
  );

  adc_conv_shift #(.RES_W(RES_W)) u_shift (
    .clk_i   (sclk_i),
    .rst_ni  (rst_eff_n),
    .load_i  (byte_done),
    .result_i(result_i),
    .strb_o  (strb),
    .dout_o  (dout_o),
    .last_o  (last_bit)
  );

  adc_pwr_ctl u_pwr (
    .clk_i  (sclk_i),
    .rst_ni (rst_eff_n),
    .start_i(byte_done),
    .last_i (last_bit),
    .strb_i (strb),
    .req_i  (pwr_req_o),
    .mode_o (mode)
  );

  assign strb_o      = strb;
  assign dout_oe_o   = !cs_ni;
  assign strb_oe_o   = !cs_ni;
  assign pwr_state_o = shdn_ni ? mode : PWR_DOWN;

endmodule

// File: tb/tb_adc_serial_port.sv
module tb_adc_serial_port;
  localparam int CLK_PERIOD = 10;
  localparam int NREC = 256;

  typedef struct packed {
    logic [7:0]  ctrl;
    logic [11:0] res;
    logic [5:0]  len;
  } vec_t;

  // ctrl byte, result word, frame length in clocks
  localparam vec_t VECS [4] = '{
    {8'hB3, 12'hA5C, 6'd16},
    {8'hD2, 12'h3F1, 6'd24},
    {8'hF1, 12'h800, 6'd16},
    {8'h80, 12'h001, 6'd24}
  };

  logic sclk = 1'b0;
  logic rst_ni, cs_ni, din, shdn_ni;
  logic [11:0] result;
  logic dout, dout_oe, strb, strb_oe;
  logic [2:0] chan;
  logic [1:0] pwr_req, pwr_state;

  int n_chk = 0;
  int n_fail = 0;
  int cyc = 0;
  logic       r_strb [NREC];
  logic       r_dout [NREC];
  logic [2:0] r_chan [NREC];
  logic [1:0] r_preq [NREC];
  logic [1:0] r_pst  [NREC];
  int starts [4];

  always #(CLK_PERIOD/2) sclk = ~sclk;

  adc_serial_port dut (
    .sclk_i(sclk), .rst_ni(rst_ni), .cs_ni(cs_ni), .din_i(din),
    .shdn_ni(shdn_ni), .result_i(result), .dout_o(dout),
    .dout_oe_o(dout_oe), .strb_o(strb), .strb_oe_o(strb_oe),
    .chan_o(chan), .pwr_req_o(pwr_req), .pwr_state_o(pwr_state)
  );

  task automatic chk(input string tag, input int act, input int exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // drive one bit for rising edge, record outputs after following falling edge
  task automatic step(input logic d);
    din = d;
    @(posedge sclk);
    @(negedge sclk);
    #1;
    if (cyc < NREC) begin
      r_strb[cyc] = strb; r_dout[cyc] = dout; r_chan[cyc] = chan;
      r_preq[cyc] = pwr_req; r_pst[cyc] = pwr_state;
    end
    cyc++;
  endtask

  task automatic send_byte(input logic [7:0] b);
    for (int i = 7; i >= 0; i--) step(b[i]);
  endtask

  function automatic int word_at(input int s);
    int w = 0;
    for (int i = 0; i < 12; i++) w = (w << 1) | int'(r_dout[s + i]);
    return w;
  endfunction

  function automatic int strb_count(input int a, input int b);
    int n = 0;
    for (int i = a; i < b; i++) n += int'(r_strb[i]);
    return n;
  endfunction

  initial begin
    #(CLK_PERIOD * 100000);
    n_fail++;
    $display("FAIL watchdog expired actual=0 expected=1");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    int s;
    rst_ni = 1'b0; cs_ni = 1'b1; din = 1'b0; shdn_ni = 1'b1; result = '0;
    #(2*CLK_PERIOD + 3);
    rst_ni = 1'b1;

    // reset state, R10
    chk("R10 strobe after reset", strb, 0);
    chk("R10 dout after reset", dout, 0);
    chk("R10 pwr_state after reset", pwr_state, 2'b11);
    chk("R10 pwr_req after reset", pwr_req, 2'b11);
    chk("R10 chan after reset", chan, 0);

    // R5 + R1: high din with cs high, then cs low with zeros
    cyc = 0;
    for (int i = 0; i < 4; i++) step(1'b1);
    chk("R5 oe low with cs high", {dout_oe, strb_oe}, 0);
    cs_ni = 1'b0;
    #1;
    chk("R5 oe high with cs low", {dout_oe, strb_oe}, 2'b11);
    cyc = 0;
    for (int i = 0; i < 24; i++) step(1'b0);
    chk("R1 no start without high din under cs", strb_count(0, 24), 0);
    chk("R10 dout zero before any conversion", word_at(0) | word_at(12), 0);

    // table walk: back-to-back 16 and 24 clock frames
    cyc = 0;
    for (int v = 0; v < 4; v++) begin
      starts[v] = cyc;
      result = VECS[v].res;
      send_byte(VECS[v].ctrl);
      for (int i = 8; i < int'(VECS[v].len); i++) step(1'b0);
    end
    for (int i = 0; i < 24; i++) step(1'b0);
    for (int v = 0; v < 4; v++) begin
      s = starts[v];
      chk($sformatf("R3 strobe at byte end v%0d", v), r_strb[s+7], 1);
      chk($sformatf("R3 single strobe per frame v%0d", v), strb_count(s, s + int'(VECS[v].len)), 1);
      chk($sformatf("R4 result MSB first v%0d", v), word_at(s + 8), VECS[v].res);
      chk($sformatf("R2 chan field v%0d", v), r_chan[s+8], VECS[v].ctrl[6:4]);
      chk($sformatf("R2 pwr field v%0d", v), r_preq[s+8], VECS[v].ctrl[1:0]);
      chk($sformatf("R8 active during conversion v%0d", v), r_pst[s+8], 2'b11);
      chk($sformatf("R8 deferred before last bit v%0d", v), r_pst[s+18], 2'b11);
      chk($sformatf("R8 applied at last bit v%0d", v), r_pst[s+19], VECS[v].ctrl[1:0]);
    end

    // R6: high din during conversion ignored, relock after bit 6
    cyc = 0;
    result = 12'h5A3;
    send_byte(8'hC7);
    for (int i = 8; i < 14; i++) step(1'b1);
    send_byte(8'h93);
    for (int i = 0; i < 24; i++) step(1'b0);
    chk("R3 first strobe", r_strb[7], 1);
    chk("R6 din ignored while busy", strb_count(8, 21), 0);
    chk("R6 first result undisturbed", word_at(8), 12'h5A3);
    chk("R6 relock start accepted", r_strb[21], 1);
    chk("R6 second result", word_at(22), 12'h5A3);
    chk("R2 chan from second byte", r_chan[22], 3'b001);

    // R7: garbage then 16 zeros then a clean frame
    cyc = 0;
    result = 12'h6C9;
    step(1'b1); step(1'b0); step(1'b1);
    for (int i = 0; i < 16; i++) step(1'b0);
    s = cyc;
    send_byte(8'hA3);
    for (int i = 0; i < 24; i++) step(1'b0);
    chk("R7 strobe after resync", r_strb[s+7], 1);
    chk("R7 data after resync", word_at(s + 8), 12'h6C9);

    // R9: shutdown mid-conversion
    cyc = 0;
    result = 12'hFFF;
    send_byte(8'hB2);
    for (int i = 8; i < 12; i++) step(1'b0);
    chk("R4 data high before shutdown", dout, 1);
    shdn_ni = 1'b0;
    #1;
    chk("R9 dout cleared by shutdown", dout, 0);
    chk("R9 strobe low in shutdown", strb, 0);
    chk("R9 power down in shutdown", pwr_state, 2'b00);
    step(1'b0); step(1'b0);
    shdn_ni = 1'b1;
    s = cyc;
    for (int i = 0; i < 15; i++) step(1'b0);
    chk("R9 no resume after shutdown", word_at(s) | int'(r_dout[s+12]) | strb_count(s, s + 15), 0);
    chk("R9 active after release", pwr_state, 2'b11);
    result = 12'h0F0;
    s = cyc;
    send_byte(8'hB3);
    for (int i = 0; i < 24; i++) step(1'b0);
    chk("R9 new start works after shutdown", word_at(s + 8), 12'h0F0);

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule